// File: doc/BRIEF.md
# Buffered Dual-Channel Input Capture Unit

This block records the value of an external 16-bit free-running counter whenever a chosen transition appears on one of its capture pins. There are two channel pairs. Each pair has a primary register (A or B) and a secondary register (C or D). When a pair's buffering is off, its secondary register is an independent capture register with its own pin and edge choice. When buffering is on, the secondary register holds the previous primary value. Each new primary capture first pushes the old primary contents into the secondary register. Its own pin is then ignored.

In buffered mode the two edge-select bits of the pair set how the primary pin triggers. Equal bits give capture on the one selected transition. Unequal bits give capture on both transitions. Every capture pin goes through a synchroniser before edge detection. Each capture raises a sticky event flag. A byte-wide read path returns the 16-bit registers as two bytes. Reading the high byte also latches the low byte, so the two halves always come from the same value.

Top module: `dual_capture_unit`

## Requirements
- R1: After reset, all four capture registers, all four flags and `rd_data_o` are zero.
- R2: With buffering off for a pair, each register captures `count_i` on the selected transition of its own pin. `cap_pin_i` bit 0 drives register A, bit 1 drives B, bit 2 drives C and bit 3 drives D. `edge_sel_i` uses the same bit order; a bit value of 1 selects the rising edge and 0 the falling edge. The captured value is `count_i` as it stands at the third rising clock edge after the pin changes.
- R3: In single-edge operation, the transition that is not selected changes no register and no flag.
- R4: With `buf_en_i[0]` set, a trigger on pin 0 moves register A into register C and loads `count_i` into A. Pin 2 is ignored, and only flag bit 0 is set.
- R5: With `buf_en_i[1]` set, register D buffers register B in the same way. Pin 3 is ignored, and only flag bit 1 is set.
- R6: In buffered mode, when a pair's primary and secondary edge-select bits differ, both rising and falling edges of the primary pin capture.
- R7: In buffered mode, when the two bits are equal, only the edge selected by that value captures.
- R8: A capture sets the register's flag bit. The bit stays set until a cycle with the matching `flag_clr_i` bit at 1 clears it. If a capture and a clear fall in the same cycle, the flag stays set.
- R9: A read with `rd_en_i` high appears on `rd_data_o` after the next rising clock edge, and `rd_data_o` holds its value when no read is made. `rd_sel_i` selects the register: 0 is A, 1 is B, 2 is C and 3 is D. A read with `rd_hi_i` = 1 returns bits 15:8 and latches bits 7:0 into the temporary byte. A read with `rd_hi_i` = 0 returns the latched byte.
- R10: A high-byte read that happens in the same cycle as a capture into that register returns the pre-capture high byte and latches the pre-capture low byte.
- R11: A capture pulse that lasts 2 clock periods is captured in single-edge mode. A pulse that lasts 3 clock periods gives two captures in both-edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | 16 | Free-running counter value |
| cap_pin_i | input | 4 | Capture pins for A, B, C, D (bits 0 to 3) |
| buf_en_i | input | 2 | Buffer enable: bit 0 for pair A/C, bit 1 for pair B/D |
| edge_sel_i | input | 4 | Edge select per register: 1 = rising, 0 = falling |
| flag_clr_i | input | 4 | Clear pulses for the flags, one bit per flag |
| flag_o | output | 4 | Sticky capture flags for A, B, C, D |
| rd_en_i | input | 1 | Byte read strobe |
| rd_sel_i | input | 2 | Register select for a read |
| rd_hi_i | input | 1 | 1 = high byte (and latch the low byte), 0 = latched low byte |
| rd_data_o | output | 8 | Registered read data |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a capture and a high-byte read of the same register. The bench places the read strobe two falling edges after the pin toggle, so the read and the capture load fall on the same rising edge. It then expects both returned bytes to carry the old register value. The second pair is a flag set and a flag clear. The bench times the clear pulse the same way and expects the flag to stay set.

// File: rtl/cap_pkg.sv
package cap_pkg;
   // Register indices, which are also the read select encoding.
   typedef enum logic [1:0] {
      REG_A = 2'd0,
      REG_B = 2'd1,
      REG_C = 2'd2,
      REG_D = 2'd3
   } cap_reg_e;

   localparam int unsigned NUM_PAIRS = 2;
   localparam int unsigned NUM_REGS  = 2 * NUM_PAIRS;
endpackage

// File: rtl/cap_edge_detect.sv
module cap_edge_detect #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);
   localparam int unsigned TOP = SYNC_STAGES - 1;

   initial begin
      assert (SYNC_STAGES >= 2) else $fatal(1, "cap_edge_detect: SYNC_STAGES must be 2 or more");
   end

   logic [TOP:0] sync_q;
   logic         prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[TOP-1:0], pin_i};
         prev_q <= sync_q[TOP];
      end
   end

   assign rise_o = sync_q[TOP] & ~prev_q;
   assign fall_o = ~sync_q[TOP] & prev_q;
endmodule

// File: rtl/cap_pair.sv
module cap_pair #(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] count_i,
   input  logic          buf_en_i,
   input  logic          es_pri_i,
   input  logic          es_sec_i,
   input  logic          rise_pri_i,
   input  logic          fall_pri_i,
   input  logic          rise_sec_i,
   input  logic          fall_sec_i,
   output logic [CW-1:0] pri_q,
   output logic [CW-1:0] sec_q,
   output logic          hit_pri_o,
   output logic          hit_sec_o
);
   logic one_edge_pri;
   logic both_edges;

   assign one_edge_pri = es_pri_i ? rise_pri_i : fall_pri_i;
   assign both_edges   = buf_en_i & (es_pri_i ^ es_sec_i);
   assign hit_pri_o    = both_edges ? (rise_pri_i | fall_pri_i) : one_edge_pri;
   assign hit_sec_o    = ~buf_en_i & (es_sec_i ? rise_sec_i : fall_sec_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pri_q <= '0;
         sec_q <= '0;
      end else begin
         if (hit_pri_o) begin
            pri_q <= count_i;
            if (buf_en_i) sec_q <= pri_q;
         end
         if (hit_sec_o) sec_q <= count_i;
      end
   end
endmodule

// File: rtl/cap_flags.sv
module cap_flags #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o <= '0;
      else        flag_o <= (flag_o & ~clr_i) | set_i;
   end
endmodule

// File: rtl/cap_read_port.sv
module cap_read_port #(
   parameter int unsigned CW   = 16,
   parameter int unsigned BW   = 8,
   parameter int unsigned NREG = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NREG*CW-1:0]      regs_i,
   input  logic                    rd_en_i,
   input  logic [$clog2(NREG)-1:0] rd_sel_i,
   input  logic                    rd_hi_i,
   output logic [BW-1:0]           rd_data_o
);
   logic [CW-1:0] word;
   logic [BW-1:0] temp_q;

   initial begin
      assert (CW == 2 * BW) else $fatal(1, "cap_read_port: CW must be twice BW");
   end

   assign word = regs_i[rd_sel_i*CW +: CW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data_o <= '0;
         temp_q    <= '0;
      end else if (rd_en_i) begin
         if (rd_hi_i) begin
            rd_data_o <= word[CW-1:BW];
            temp_q    <= word[BW-1:0];
         end else begin
            rd_data_o <= temp_q;
         end
      end
   end
endmodule

// File: rtl/dual_capture_unit.sv
module dual_capture_unit #(
   parameter int unsigned CW          = 16,
   parameter int unsigned BW          = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] count_i,
   input  logic [3:0]    cap_pin_i,
   input  logic [1:0]    buf_en_i,
   input  logic [3:0]    edge_sel_i,
   input  logic [3:0]    flag_clr_i,
   output logic [3:0]    flag_o,
   input  logic          rd_en_i,
   input  logic [1:0]    rd_sel_i,
   input  logic          rd_hi_i,
   output logic [BW-1:0] rd_data_o
);
   import cap_pkg::*;

   localparam int unsigned NP   = NUM_PAIRS;
   localparam int unsigned NREG = NUM_REGS;

   initial begin
      assert (CW == 2 * BW) else $fatal(1, "dual_capture_unit: CW must be twice BW");
      assert (SYNC_STAGES >= 2) else $fatal(1, "dual_capture_unit: SYNC_STAGES too small");
   end

   logic [NREG-1:0]    rise;
   logic [NREG-1:0]    fall;
   logic [NREG-1:0]    hit;
   logic [NREG*CW-1:0] cap_flat;

   for (genvar i = 0; i < NREG; i++) begin : g_pin
      cap_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_i  (cap_pin_i[i]),
         .rise_o (rise[i]),
         .fall_o (fall[i])
      );
   end

   for (genvar p = 0; p < NP; p++) begin : g_pair
      cap_pair #(.CW(CW)) u_pair (
         .clk        (clk),
         .rst_n      (rst_n),
         .count_i    (count_i),
         .buf_en_i   (buf_en_i[p]),
         .es_pri_i   (edge_sel_i[p]),
         .es_sec_i   (edge_sel_i[p+NP]),
         .rise_pri_i (rise[p]),
         .fall_pri_i (fall[p]),
         .rise_sec_i (rise[p+NP]),
         .fall_sec_i (fall[p+NP]),
         .pri_q      (cap_flat[p*CW +: CW]),
         .sec_q      (cap_flat[(p+NP)*CW +: CW]),
         .hit_pri_o  (hit[p]),
         .hit_sec_o  (hit[p+NP])
      );
   end

   cap_flags #(.N(NREG)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (hit),
      .clr_i  (flag_clr_i),
      .flag_o (flag_o)
   );

   cap_read_port #(.CW(CW), .BW(BW), .NREG(NREG)) u_read (
      .clk       (clk),
      .rst_n     (rst_n),
      .regs_i    (cap_flat),
      .rd_en_i   (rd_en_i),
      .rd_sel_i  (rd_sel_i),
      .rd_hi_i   (rd_hi_i),
      .rd_data_o (rd_data_o)
   );
endmodule

// File: rtl/dual_capture_unit_chk.sv
module dual_capture_unit_chk #(
   parameter int unsigned CW   = 16,
   parameter int unsigned BW   = 8,
   parameter int unsigned NREG = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         buf_en_i,
   input logic [3:0]         flag_clr_i,
   input logic [3:0]         flag_o,
   input logic               rd_en_i,
   input logic [BW-1:0]      rd_data_o,
   input logic [NREG*CW-1:0] cap_flat
);
   localparam int unsigned NP = NREG / 2;

   for (genvar p = 0; p < NP; p++) begin : g_pair_chk
      // R4 / R5: in buffered mode a primary update shifts the old value down
      p_buffer_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(buf_en_i[p]) && (cap_flat[p*CW +: CW] != $past(cap_flat[p*CW +: CW])))
         |-> (cap_flat[(p+NP)*CW +: CW] == $past(cap_flat[p*CW +: CW])));

      // R2: a primary register only changes together with its flag being set
      p_capture_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (cap_flat[p*CW +: CW] != $past(cap_flat[p*CW +: CW])) |-> flag_o[p]);
   end

   for (genvar i = 0; i < NREG; i++) begin : g_flag_chk
      // R8: a flag drops only after a clear request
      p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(flag_o[i]) |-> $past(flag_clr_i[i]));
   end

   // R9: read data holds while no read is requested
   p_read_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_en_i) |-> $stable(rd_data_o));
endmodule

bind dual_capture_unit dual_capture_unit_chk #(.CW(CW), .BW(BW), .NREG(NREG)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .buf_en_i   (buf_en_i),
   .flag_clr_i (flag_clr_i),
   .flag_o     (flag_o),
   .rd_en_i    (rd_en_i),
   .rd_data_o  (rd_data_o),
   .cap_flat   (cap_flat)
);

// File: tb/sim_dual_capture_unit.sv
module sim_dual_capture_unit;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] count;
   logic [3:0]  pins;
   logic [1:0]  buf_en;
   logic [3:0]  es;
   logic [3:0]  flag_clr;
   logic [3:0]  flag;
   logic        rd_en;
   logic [1:0]  rd_sel;
   logic        rd_hi;
   logic [7:0]  rd_data;

   int checks = 0;
   int errors = 0;
   logic [15:0] exp_r [4];
   logic [3:0]  exp_f;

   always #2 clk = ~clk;

   dual_capture_unit u0 (
      .clk(clk), .rst_n(rst_n), .count_i(count), .cap_pin_i(pins),
      .buf_en_i(buf_en), .edge_sel_i(es), .flag_clr_i(flag_clr), .flag_o(flag),
      .rd_en_i(rd_en), .rd_sel_i(rd_sel), .rd_hi_i(rd_hi), .rd_data_o(rd_data)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic read16(input logic [1:0] sel, output logic [15:0] v);
      @(negedge clk); rd_en = 1'b1; rd_sel = sel; rd_hi = 1'b1;
      @(negedge clk); v[15:8] = rd_data; rd_hi = 1'b0;
      @(negedge clk); v[7:0] = rd_data; rd_en = 1'b0;
   endtask

   task automatic set_pin(input int i, input logic lvl, input logic [15:0] cnt);
      @(negedge clk); count = cnt; pins[i] = lvl;
      tick(4);
   endtask

   task automatic clear_flags(input logic [3:0] m);
      @(negedge clk); flag_clr = m;
      @(negedge clk); flag_clr = 4'b0;
   endtask

   task automatic check_all(input string tag);
      logic [15:0] v;
      for (int j = 0; j < 4; j++) begin
         read16(j[1:0], v);
         chk($sformatf("%s reg%0d", tag, j), v, exp_r[j]);
      end
      chk($sformatf("%s flags (R8)", tag), flag, exp_f);
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] v;
      logic [15:0] cnt;
      logic        lvl;
      logic        hit;
      rst_n = 1'b0; count = 16'h0; pins = 4'b0; buf_en = 2'b0; es = 4'b0;
      flag_clr = 4'b0; rd_en = 1'b0; rd_sel = 2'b0; rd_hi = 1'b0;
      for (int j = 0; j < 4; j++) exp_r[j] = 16'h0;
      exp_f = 4'b0;
      tick(3);
      chk("R1 rd_data at reset", rd_data, 0);
      rst_n = 1'b1;
      tick(2);
      check_all("R1");

      // R2 / R3: unbuffered sweep over every register, edge choice and transition
      for (int i = 0; i < 4; i++) begin
         for (int e = 0; e < 2; e++) begin
            es[i] = e[0];
            for (int t = 0; t < 2; t++) begin
               lvl = (t == 0);
               cnt = 16'h1000 + 16'(i * 256 + e * 16 + t + 1);
               hit = (lvl == e[0]);
               set_pin(i, lvl, cnt);
               if (hit) begin
                  exp_r[i] = cnt;
                  exp_f[i] = 1'b1;
               end
               check_all(hit ? "R2 capture" : "R3 ignored edge");
            end
         end
      end
      clear_flags(4'hF);
      exp_f = 4'b0;
      tick(1);
      chk("R8 clear all", flag, 0);

      // R4 / R7: buffered pair A with equal rising edge bits
      buf_en = 2'b01; es = 4'b0101;
      set_pin(0, 1'b1, 16'hA001);
      exp_r[2] = exp_r[0]; exp_r[0] = 16'hA001; exp_f[0] = 1'b1;
      check_all("R4 buffered rise");
      set_pin(0, 1'b0, 16'hA002);
      check_all("R7 falling edge ignored");
      set_pin(2, 1'b1, 16'hA003);
      set_pin(2, 1'b0, 16'hA004);
      check_all("R4 pin C ignored");

      // R6: unequal bits give both edges
      es[2] = 1'b0;
      set_pin(0, 1'b1, 16'hA005);
      exp_r[2] = exp_r[0]; exp_r[0] = 16'hA005;
      check_all("R6 both edges rise");
      set_pin(0, 1'b0, 16'hA006);
      exp_r[2] = exp_r[0]; exp_r[0] = 16'hA006;
      check_all("R6 both edges fall");

      // R5 / R7: buffered pair B with equal falling edge bits
      buf_en = 2'b11; es[1] = 1'b0; es[3] = 1'b0;
      set_pin(1, 1'b1, 16'hB001);
      check_all("R7 pair B rise ignored");
      set_pin(1, 1'b0, 16'hB002);
      exp_r[3] = exp_r[1]; exp_r[1] = 16'hB002; exp_f[1] = 1'b1;
      check_all("R5 buffered fall");
      set_pin(3, 1'b1, 16'hB003);
      set_pin(3, 1'b0, 16'hB004);
      check_all("R5 pin D ignored");

      // R11: three-period pulse in both-edge mode gives two captures
      @(negedge clk); count = 16'hC001; pins[0] = 1'b1;
      tick(3);
      count = 16'hC002; pins[0] = 1'b0;
      tick(4);
      exp_r[2] = 16'hC001; exp_r[0] = 16'hC002;
      check_all("R11 both-edge short pulse");

      // R11: two-period pulse in single-edge mode
      buf_en = 2'b00; es[0] = 1'b1;
      @(negedge clk); count = 16'hC003; pins[0] = 1'b1;
      tick(2);
      pins[0] = 1'b0;
      tick(4);
      exp_r[0] = 16'hC003;
      check_all("R11 single-edge short pulse");

      // R8: clear and capture on the same edge leaves the flag set
      clear_flags(4'hF);
      exp_f = 4'b0;
      @(negedge clk); count = 16'hD001; pins[0] = 1'b1;
      @(negedge clk);
      @(negedge clk); flag_clr = 4'b0001;
      @(negedge clk); flag_clr = 4'b0000;
      exp_r[0] = 16'hD001; exp_f[0] = 1'b1;
      chk("R8 set wins over clear", flag, 4'b0001);
      clear_flags(4'b0001);
      exp_f[0] = 1'b0;
      tick(1);
      chk("R8 clear by write one", flag, 0);
      pins[0] = 1'b0;
      tick(4);

      // R10: read coinciding with a capture returns the old value
      @(negedge clk); count = 16'hE00F; pins[0] = 1'b1;
      @(negedge clk);
      @(negedge clk); rd_en = 1'b1; rd_sel = 2'd0; rd_hi = 1'b1;
      @(negedge clk); v[15:8] = rd_data; rd_hi = 1'b0;
      @(negedge clk); v[7:0] = rd_data; rd_en = 1'b0;
      chk("R10 read during capture", v, exp_r[0]);
      exp_r[0] = 16'hE00F; exp_f[0] = 1'b1;
      tick(2);
      check_all("R10 after capture");

      // R9: low byte comes from the latch, not the live register
      read16(2'd1, v);
      @(negedge clk); rd_en = 1'b1; rd_sel = 2'd0; rd_hi = 1'b0;
      @(negedge clk); rd_en = 1'b0;
      chk("R9 low byte from latch", rd_data, exp_r[1][7:0]);
      tick(3);
      chk("R9 data holds", rd_data, exp_r[1][7:0]);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule